// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block forms the status word that a host sees on the data bus of a NOR flash while an internal program or erase runs. A command decoder hands it four command kinds: program, erase, suspend and resume. The block keeps the operation state itself (idle, programming, erasing, erase held, programming while erase is held). A down-counter stands in for the length of the embedded algorithm. While an operation runs, each read cycle returns a status word rather than array data. The block also drives a ready/busy line.

The status word has three live bits. Bit 6 flips on every read while any operation is busy. Bit 2 flips only when the sector being read is marked for erase, so the host can find out which sectors an erase covers. Bit 7 is a polling bit: it holds a known value while the work runs and gives way to the array data when the work ends. A read cycle starts at a falling edge of the active-low output-enable, which is sampled on the clock. Addresses arrive already reduced to a sector index. The array contents come in from outside on a data input.

Top module: `flash_status_gen`

## Requirements
- R1: A synchronous active-high reset returns `ready` to 1 and `dq` to 0, and clears both toggle bits. After reset, the first status read during an operation shows bit 6 and bit 2 (when enabled) as 1.
- R2: A command is taken at a rising edge where `cmd_valid` is 1. `cmd_op` encodes 0 as program, 1 as erase, 2 as suspend and 3 as resume. Program and erase start only from idle, and `ready` is 0 from that same edge.
- R3: A program holds `ready` at 0 for exactly PROG_CYCLES clock cycles. An erase holds `ready` at 0 for exactly ERASE_CYCLES cycles of active erasing, and cycles spent suspended do not count.
- R4: A read cycle is a falling edge of `oe_n`. Status bit 6 inverts on every read cycle while a program or an active erase is busy.
- R5: Status bit 2 inverts on a read cycle only when the sector read has its `erase_sel` flag set and the state is erasing or erase-suspended. Otherwise it keeps its last value in status words.
- R6: Status bit 7 is the inverse of `prog_poll_bit` during a program. It is 0 during an active erase, and 1 when an erase-selected sector is read while suspended. All other status bits are 0.
- R7: A suspend command during an erase sets `ready` to 1 and freezes bit 6. While suspended, reads of sectors without `erase_sel` return `array_rdata`. A resume command drops `ready` to 0 and continues the erase.
- R8: While suspended, a program to a sector without `erase_sel` runs as a normal program and then returns to the suspended state. A program to an erase-selected sector is ignored.
- R9: In idle, including after an operation completes, a read cycle returns `array_rdata`. `dq` changes only on a read cycle.
- R10: While a program or erase is busy, program and erase commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command kind (0 program, 1 erase, 2 suspend, 3 resume) |
| cmd_sector | input | clog2(SECTORS) | Target sector of a program command |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed |
| erase_sel | input | SECTORS | Per-sector erase-selected flags |
| rd_sector | input | clog2(SECTORS) | Sector index of the current read |
| oe_n | input | 1 | Active-low output enable; a falling edge starts a read |
| array_rdata | input | DATA_W | Array data at the read address |
| dq | output | DATA_W | Registered read data or status word |
| ready | output | 1 | Ready (1) or busy (0) |

## Verification
`oe_n` is sampled on the clock, so a read result appears in `dq` at the first rising edge that sees `oe_n` low. The bench drives `oe_n` low at a falling edge and reads `dq` at the next falling edge. `ready` changes at the edge that accepts a command and at the edge where the counter expires. The bench drives commands at falling edges, checks `ready` one edge later, and measures how long each operation is busy by counting clock edges until `ready` returns. The expected toggle values come from a model of the two bits that the bench keeps itself, advanced once per read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_SUSP   = 2'd2,
    OP_RESUME = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PROG  = 3'd1,
    S_ERASE = 3'd2,
    S_ESUSP = 3'd3,
    S_SPROG = 3'd4
  } st_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_SECT = 2;

  function automatic logic is_busy(st_e s);
    return (s == S_PROG) || (s == S_ERASE) || (s == S_SPROG);
  endfunction
endpackage

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_sel,
  input  logic       cmd_poll,
  output st_e        st,
  output logic       ready,
  output logic       prog_msb
);
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  st_e              st_n;
  logic [CNT_W-1:0] prg_cnt;
  logic [CNT_W-1:0] ers_cnt;
  logic             prg_enter;
  logic             ers_enter;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: begin
        if (cmd_valid && cmd_op == OP_PROG)       st_n = S_PROG;
        else if (cmd_valid && cmd_op == OP_ERASE) st_n = S_ERASE;
      end
      S_PROG:  if (prg_cnt == '0) st_n = S_IDLE;
      S_SPROG: if (prg_cnt == '0) st_n = S_ESUSP;
      S_ERASE: begin
        if (ers_cnt == '0)                             st_n = S_IDLE;
        else if (cmd_valid && cmd_op == OP_SUSP)       st_n = S_ESUSP;
      end
      S_ESUSP: begin
        if (cmd_valid && cmd_op == OP_RESUME)          st_n = S_ERASE;
        else if (cmd_valid && cmd_op == OP_PROG && !cmd_sel) st_n = S_SPROG;
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign prg_enter = (st_n == S_PROG || st_n == S_SPROG) && !(st == S_PROG || st == S_SPROG);
  assign ers_enter = (st == S_IDLE) && (st_n == S_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ready    <= 1'b1;
      prg_cnt  <= '0;
      ers_cnt  <= '0;
      prog_msb <= 1'b0;
    end else begin
      st    <= st_n;
      ready <= !is_busy(st_n);
      if (prg_enter) begin
        prg_cnt  <= CNT_W'(PROG_CYCLES - 1);
        prog_msb <= cmd_poll;
      end else if ((st == S_PROG || st == S_SPROG) && prg_cnt != '0) begin
        prg_cnt <= prg_cnt - 1'b1;
      end
      if (ers_enter) begin
        ers_cnt <= CNT_W'(ERASE_CYCLES - 1);
      end else if (st == S_ERASE && ers_cnt != '0) begin
        ers_cnt <= ers_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_read_toggle.sv
module flash_read_toggle (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic busy,
  input  logic tgl2_en,
  output logic rd_stb,
  output logic t6,
  output logic t2,
  output logic t6_n,
  output logic t2_n
);
  logic oe_q;

  assign rd_stb = oe_q && !oe_n;
  assign t6_n   = t6 ^ (rd_stb && busy);
  assign t2_n   = t2 ^ (rd_stb && tgl2_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b1;
      t6   <= 1'b0;
      t2   <= 1'b0;
    end else begin
      oe_q <= oe_n;
      t6   <= t6_n;
      t2   <= t2_n;
    end
  end
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  st_e               st,
  input  logic              addr_sel,
  input  logic              prog_msb,
  input  logic              t6_n,
  input  logic              t2_n,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dq
);
  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] word;

  always_comb begin
    stat           = '0;
    stat[BIT_TGL]  = t6_n;
    stat[BIT_SECT] = t2_n;
    case (st)
      S_PROG, S_SPROG: stat[BIT_POLL] = !prog_msb;
      S_ERASE:         stat[BIT_POLL] = 1'b0;
      default:         stat[BIT_POLL] = 1'b1;
    endcase
  end

  always_comb begin
    case (st)
      S_PROG, S_SPROG, S_ERASE: word = stat;
      S_ESUSP:                  word = addr_sel ? stat : array_rdata;
      default:                  word = array_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         dq <= '0;
    else if (rd_stb) dq <= word;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int SECTORS      = 8,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 300
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(SECTORS)-1:0] cmd_sector,
  input  logic                       prog_poll_bit,
  input  logic [SECTORS-1:0]         erase_sel,
  input  logic [$clog2(SECTORS)-1:0] rd_sector,
  input  logic                       oe_n,
  input  logic [DATA_W-1:0]          array_rdata,
  output logic [DATA_W-1:0]          dq,
  output logic                       ready
);
  st_e  st;
  logic prog_msb;
  logic cmd_sel;
  logic addr_sel;
  logic busy;
  logic tgl2_en;
  logic rd_stb;
  logic t6, t2, t6_n, t2_n;

  assign cmd_sel  = erase_sel[cmd_sector];
  assign addr_sel = erase_sel[rd_sector];
  assign busy     = is_busy(st);
  assign tgl2_en  = addr_sel && (st == S_ERASE || st == S_ESUSP);

  flash_op_seq #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_sel  (cmd_sel),
    .cmd_poll (prog_poll_bit),
    .st       (st),
    .ready    (ready),
    .prog_msb (prog_msb)
  );

  flash_read_toggle i_tgl (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .busy   (busy),
    .tgl2_en(tgl2_en),
    .rd_stb (rd_stb),
    .t6     (t6),
    .t2     (t2),
    .t6_n   (t6_n),
    .t2_n   (t2_n)
  );

  flash_status_mux #(
    .DATA_W(DATA_W)
  ) i_mux (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .st         (st),
    .addr_sel   (addr_sel),
    .prog_msb   (prog_msb),
    .t6_n       (t6_n),
    .t2_n       (t2_n),
    .array_rdata(array_rdata),
    .dq         (dq)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              rd_stb,
  input logic              addr_sel,
  input st_e               st,
  input logic              prog_msb,
  input logic              t6,
  input logic              t2,
  input logic [DATA_W-1:0] dq,
  input logic              ready
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ready && dq == '0));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd1)) |=> !ready);

  assert_toggle6_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (st == S_PROG || st == S_ERASE || st == S_SPROG)) |=> (t6 != $past(t6)));

  assert_toggle2_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !addr_sel) |=> (t2 == $past(t2)));

  assert_poll_prog_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == S_PROG) |=> (dq[BIT_POLL] != $past(prog_msb)));

  assert_suspend_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_ERASE && cmd_valid && cmd_op == 2'd2) |=> (ready || st == S_IDLE));

  assert_dq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(dq));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROG && cmd_valid && cmd_op == 2'd1) |=> (st != S_ERASE));
endmodule

bind flash_status_gen flash_status_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .rd_stb   (rd_stb),
  .addr_sel (addr_sel),
  .st       (st),
  .prog_msb (prog_msb),
  .t6       (t6),
  .t2       (t2),
  .dq       (dq),
  .ready    (ready)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SECTORS    = 8;
  localparam int DATA_W     = 8;
  localparam int PCYC       = 12;
  localparam int ECYC       = 300;

  // Reads during an erase with sectors 0 and 2 selected, starting from cleared toggles:
  // {sector, expected status word}
  localparam logic [10:0] VEC [0:7] = '{
    {3'd0, 8'h44}, {3'd1, 8'h04}, {3'd2, 8'h40}, {3'd3, 8'h00},
    {3'd0, 8'h44}, {3'd0, 8'h00}, {3'd5, 8'h40}, {3'd2, 8'h04}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'd0;
  logic [2:0]        cmd_sector = 3'd0;
  logic              prog_poll_bit = 1'b0;
  logic [SECTORS-1:0] erase_sel = '0;
  logic [2:0]        rd_sector = 3'd0;
  logic              oe_n = 1'b1;
  logic [DATA_W-1:0] array_rdata = '0;
  logic [DATA_W-1:0] dq;
  logic              ready;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int t_a, t_s, t_r, t_d;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_status_gen #(
    .SECTORS(SECTORS), .DATA_W(DATA_W), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC)
  ) i_flash_status_gen (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .prog_poll_bit(prog_poll_bit), .erase_sel(erase_sel),
    .rd_sector(rd_sector), .oe_n(oe_n), .array_rdata(array_rdata),
    .dq(dq), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] sec, input logic pbit);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec; prog_poll_bit = pbit;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sec, output logic [DATA_W-1:0] val);
    @(negedge clk);
    rd_sector = sec; oe_n = 1'b0;
    @(negedge clk);
    val = dq;
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", int'(ready), 1);
    check("R1 dq after reset", int'(dq), 0);

    // R9 idle reads return array data; dq holds without a read
    array_rdata = 8'h3C;
    rd(3'd1, v); check("R9 idle read", int'(v), 'h3C);
    array_rdata = 8'h99;
    repeat (2) @(negedge clk);
    check("R9 dq held without read", int'(dq), 'h3C);

    // R2/R4/R6 program with poll bit 1
    cmd(2'd0, 3'd3, 1'b1); t_a = cyc;
    check("R2 busy after program", int'(ready), 0);
    rd(3'd3, v); check("R4 R6 program read 1", int'(v), 'h40);
    rd(3'd3, v); check("R4 program read 2", int'(v), 'h00);
    cmd(2'd1, 3'd0, 1'b0); // R10 erase while busy
    wait_ready(); t_d = cyc;
    check("R3 program duration", t_d - t_a, PCYC);
    repeat (2) @(negedge clk);
    check("R10 erase ignored while busy", int'(ready), 1);
    rd(3'd0, v); check("R9 read after completion", int'(v), 'h99);

    // R6 program with poll bit 0
    cmd(2'd0, 3'd4, 1'b0);
    rd(3'd4, v); check("R6 poll bit inverse of 0", int'(v), 'hC0);
    wait_ready();

    // R1 toggles cleared; vector table during erase (R4 R5 R6)
    do_reset();
    check("R1 ready after second reset", int'(ready), 1);
    erase_sel = 8'b0000_0101;
    cmd(2'd1, 3'd0, 1'b0); t_a = cyc;
    check("R2 busy after erase", int'(ready), 0);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][10:8], v);
      check($sformatf("R5 R4 erase vector %0d", i), int'(v), int'(VEC[i][7:0]));
    end

    // R7 suspend
    cmd(2'd2, 3'd0, 1'b0); t_s = cyc;
    check("R7 ready in suspend", int'(ready), 1);
    rd(3'd0, v); check("R7 R5 suspend read sel 0", int'(v), 'h80);
    rd(3'd2, v); check("R7 R5 suspend read sel 2", int'(v), 'h84);
    array_rdata = 8'h5A;
    rd(3'd4, v); check("R7 non-selected array data", int'(v), 'h5A);

    // R8 program into erase-selected sector ignored
    cmd(2'd0, 3'd2, 1'b0);
    check("R8 program to selected sector ignored", int'(ready), 1);
    // R8 program into non-selected sector
    cmd(2'd0, 3'd6, 1'b0);
    check("R8 program in suspend busy", int'(ready), 0);
    rd(3'd6, v); check("R8 R6 program in suspend status", int'(v), 'hC4);
    wait_ready();
    rd(3'd0, v); check("R8 back to suspend", int'(v), 'hC0);

    // R7 resume
    cmd(2'd3, 3'd0, 1'b0); t_r = cyc;
    check("R7 busy after resume", int'(ready), 0);
    rd(3'd0, v); check("R4 R5 resumed erase read", int'(v), 'h04);
    wait_ready(); t_d = cyc;
    check("R3 erase active duration", (t_s - t_a) + (t_d - t_r), ECYC);
    rd(3'd7, v); check("R9 read after erase", int'(v), 'h5A);

    // R1 reset in the middle of an operation
    cmd(2'd0, 3'd1, 1'b1);
    check("R2 busy before mid reset", int'(ready), 0);
    do_reset();
    check("R1 ready after mid reset", int'(ready), 1);
    check("R1 dq after mid reset", int'(dq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule